// File: doc/BRIEF.md
# Serial Receiver Status and Idle-Line Detector

This block sits behind the bit-level deserialiser of a serial receiver. Each time the deserialiser finishes a character it pulses `char_done` and presents the character with its noise and framing indications. The block moves the character into a parallel data register. It keeps five status flags: data ready, overrun, noise, framing error and idle line. A protection rule stops a new character from overwriting one that software has not yet collected.

The block also watches the sampled receive line. It counts bit ticks to decide when the line has been high for a full character time. The idle flag is armed only by line activity, so each idle period raises it once. Three flags (data ready, overrun and idle) can request an interrupt, under two enables. A flag is cleared by a two-step software sequence: a status read while the flag is 1, then a read of the data register.

Idle detection is a two-state machine. `IDL_DISARMED` waits for line activity. `IDL_COUNT` counts high bit times. The transition `arm` (any 0 on the line) goes from `IDL_DISARMED` to `IDL_COUNT`. The transition `restart` (a 0 on the line while counting) stays in `IDL_COUNT` and zeroes the count. The transition `fire` (the tenth high tick) returns to `IDL_DISARMED` and sets the idle flag.

Top module: `rxs_status`

## Requirements
- R1: When `char_done` is high and the data-ready flag is 0, the character is loaded into `rx_data` and `flg_ready` is 1 after the next clock edge.
- R2: When `char_done` is high while `flg_ready` is 1 and no clearing data read happens in that cycle, the character is dropped. `rx_data`, `flg_noise` and `flg_frame` keep their values, `flg_overrun` becomes 1 and `flg_ready` stays 1.
- R3: `flg_noise` and `flg_frame` are loaded from `char_noise` and `char_frame` whenever a character is accepted. They never affect `irq`.
- R4: `flg_idle` becomes 1 on the edge where the CHAR_BITS-th (default 10) `bit_tick` arrives with `line_lvl` high, counted since the last cycle in which `line_lvl` was 0.
- R5: After reset, and after each time `flg_idle` is set, the detector is disarmed. No idle flag can set until `line_lvl` has been 0 at least once.
- R6: Any cycle with `line_lvl` at 0 restarts the high-tick count from zero. Ticks in such a cycle are not counted.
- R7: `irq` is 1 exactly when (`ie_rx` and (`flg_ready` or `flg_overrun`)) or (`ie_idle` and `flg_idle`).
- R8: A flag is cleared by a `data_rd` pulse only if the most recent `stat_rd` happened while that flag was 1, and no earlier `data_rd` has already used that status read. A `data_rd` with no such prior status read clears nothing.
- R9: A character completing in the same cycle as a data read that clears data-ready is accepted rather than counted as overrun. If a flag is set and cleared in the same cycle, the set wins.
- R10: After reset, all five flags, `rx_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per received bit time |
| line_lvl | input | 1 | Sampled receive line level |
| char_done | input | 1 | Deserialiser has completed a character |
| char_data | input | DATA_W | Completed character |
| char_noise | input | 1 | Noise seen in the completed character |
| char_frame | input | 1 | Stop bit of the completed character was 0 |
| stat_rd | input | 1 | Software read of the status register |
| data_rd | input | 1 | Software read of the data register |
| ie_rx | input | 1 | Interrupt enable for data ready and overrun |
| ie_idle | input | 1 | Interrupt enable for idle line |
| rx_data | output | DATA_W | Parallel data register |
| flg_ready | output | 1 | Data-ready flag |
| flg_overrun | output | 1 | Overrun flag |
| flg_noise | output | 1 | Noise flag for the held character |
| flg_frame | output | 1 | Framing-error flag for the held character |
| flg_idle | output | 1 | Idle-line flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong clearing mask shows up at the flag outputs on the edge after the offending `data_rd`: a flag either survives a valid sequence or drops without one. A wrong overrun decision changes `rx_data` or `flg_overrun` on the edge after the colliding `char_done`. The idle state machine is internal, but an error there shows one edge after the tenth high tick, or as a flag that fires again during a quiet line. A reference model compared on every clock therefore catches any divergence within one cycle of the stimulus that exposes it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int FLAG_N  = 5;
    localparam int FL_RDY  = 0;
    localparam int FL_OVR  = 1;
    localparam int FL_NSE  = 2;
    localparam int FL_FRM  = 3;
    localparam int FL_IDL  = 4;

    typedef enum logic {
        IDL_DISARMED = 1'b0,
        IDL_COUNT    = 1'b1
    } idle_state_t;
endpackage

// File: rtl/rxs_idle_det.sv
module rxs_idle_det
    import rxs_pkg::*;
#(
    parameter int CHAR_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_lvl,
    output logic idle_set
);
    localparam int CW = $clog2(CHAR_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(CHAR_BITS - 1);

    idle_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IDL_DISARMED;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        idle_set = 1'b0;
        unique case (st)
            IDL_DISARMED: begin
                if (!line_lvl) begin          // arm
                    st_nx  = IDL_COUNT;
                    cnt_nx = '0;
                end
            end
            IDL_COUNT: begin
                if (!line_lvl) begin          // restart
                    cnt_nx = '0;
                end else if (bit_tick) begin
                    if (cnt == LAST) begin    // fire
                        idle_set = 1'b1;
                        st_nx    = IDL_DISARMED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_nx  = IDL_DISARMED;
                cnt_nx = '0;
            end
        endcase
    end
endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              char_frame,
    input  logic              idle_set,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [FLAG_N-1:0] flags,
    output logic [DATA_W-1:0] rx_data
);
    logic [FLAG_N-1:0] arm_q, arm_nx, clr, flags_nx;
    logic [DATA_W-1:0] data_nx;
    logic              accept, ovr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            arm_q   <= '0;
            rx_data <= '0;
        end else begin
            flags   <= flags_nx;
            arm_q   <= arm_nx;
            rx_data <= data_nx;
        end
    end

    always_comb begin
        clr     = data_rd ? arm_q : '0;
        arm_nx  = stat_rd ? flags : (data_rd ? '0 : arm_q);
        accept  = char_done && (!flags[FL_RDY] || clr[FL_RDY]);
        ovr_set = char_done && !accept;
        data_nx = accept ? char_data : rx_data;

        flags_nx         = flags & ~clr;
        flags_nx[FL_RDY] = flags_nx[FL_RDY] | accept;
        flags_nx[FL_OVR] = flags_nx[FL_OVR] | ovr_set;
        flags_nx[FL_IDL] = flags_nx[FL_IDL] | idle_set;
        if (accept) begin
            flags_nx[FL_NSE] = char_noise;
            flags_nx[FL_FRM] = char_frame;
        end
    end
endmodule

// File: rtl/rxs_status.sv
module rxs_status
    import rxs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CHAR_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              line_lvl,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              char_frame,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ie_rx,
    input  logic              ie_idle,
    output logic [DATA_W-1:0] rx_data,
    output logic              flg_ready,
    output logic              flg_overrun,
    output logic              flg_noise,
    output logic              flg_frame,
    output logic              flg_idle,
    output logic              irq
);
    logic              idle_set;
    logic [FLAG_N-1:0] flags;

    rxs_idle_det #(.CHAR_BITS(CHAR_BITS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .line_lvl (line_lvl),
        .idle_set (idle_set)
    );

    rxs_flag_bank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_done  (char_done),
        .char_data  (char_data),
        .char_noise (char_noise),
        .char_frame (char_frame),
        .idle_set   (idle_set),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .flags      (flags),
        .rx_data    (rx_data)
    );

    always_comb begin
        flg_ready   = flags[FL_RDY];
        flg_overrun = flags[FL_OVR];
        flg_noise   = flags[FL_NSE];
        flg_frame   = flags[FL_FRM];
        flg_idle    = flags[FL_IDL];
        irq = (ie_rx && (flags[FL_RDY] || flags[FL_OVR])) || (ie_idle && flags[FL_IDL]);
    end
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              line_lvl,
    input logic              char_done,
    input logic [DATA_W-1:0] char_data,
    input logic              data_rd,
    input logic              ie_rx,
    input logic              ie_idle,
    input logic [DATA_W-1:0] rx_data,
    input logic              flg_ready,
    input logic              flg_overrun,
    input logic              flg_idle,
    input logic              irq
);
    // R1: a character arriving on an empty register is stored
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!flg_ready && char_done) |=> (flg_ready && rx_data == $past(char_data)));

    // R2: a colliding character leaves the register untouched and flags overrun
    a_r2_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_ready && char_done && !data_rd) |=> ($stable(rx_data) && flg_overrun && flg_ready));

    // R3: with both enables off no request is raised
    a_r3_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_rx && !ie_idle) |-> !irq);

    // R4: idle can only appear after a high tick
    a_r4_idle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_idle) |-> $past(bit_tick && line_lvl));

    // R6: a low line never completes an idle period
    a_r6_low_blocks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !line_lvl |=> !$rose(flg_idle));

    // R8: without a data read, data-ready and overrun hold
    a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd && flg_ready) |=> flg_ready);
    a_r8_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd && flg_overrun) |=> flg_overrun);
endmodule

bind rxs_status rxs_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .line_lvl    (line_lvl),
    .char_done   (char_done),
    .char_data   (char_data),
    .data_rd     (data_rd),
    .ie_rx       (ie_rx),
    .ie_idle     (ie_idle),
    .rx_data     (rx_data),
    .flg_ready   (flg_ready),
    .flg_overrun (flg_overrun),
    .flg_idle    (flg_idle),
    .irq         (irq)
);

// File: tb/test_rxs_status.sv
`timescale 1ns/1ps
module test_rxs_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 0, line_lvl = 1, char_done = 0;
    logic [7:0] char_data = 0;
    logic       char_noise = 0, char_frame = 0, stat_rd = 0, data_rd = 0;
    logic       ie_rx = 0, ie_idle = 0;
    logic [7:0] rx_data;
    logic       flg_ready, flg_overrun, flg_noise, flg_frame, flg_idle, irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rxs_status i_rxs_status (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_lvl(line_lvl),
        .char_done(char_done), .char_data(char_data), .char_noise(char_noise),
        .char_frame(char_frame), .stat_rd(stat_rd), .data_rd(data_rd),
        .ie_rx(ie_rx), .ie_idle(ie_idle), .rx_data(rx_data),
        .flg_ready(flg_ready), .flg_overrun(flg_overrun), .flg_noise(flg_noise),
        .flg_frame(flg_frame), .flg_idle(flg_idle), .irq(irq)
    );

    // behavioural reference model
    int m_data;
    bit m_rdy, m_ovr, m_nse, m_frm, m_idl;
    bit a_rdy, a_ovr, a_nse, a_frm, a_idl;
    bit m_armed;
    int m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data = 0; m_rdy = 0; m_ovr = 0; m_nse = 0; m_frm = 0; m_idl = 0;
            a_rdy = 0; a_ovr = 0; a_nse = 0; a_frm = 0; a_idl = 0;
            m_armed = 0; m_cnt = 0;
        end else begin
            bit c_rdy, c_ovr, c_nse, c_frm, c_idl, take, fire;
            c_rdy = data_rd && a_rdy; c_ovr = data_rd && a_ovr;
            c_nse = data_rd && a_nse; c_frm = data_rd && a_frm;
            c_idl = data_rd && a_idl;
            if (stat_rd) begin
                a_rdy = m_rdy; a_ovr = m_ovr; a_nse = m_nse; a_frm = m_frm; a_idl = m_idl;
            end else if (data_rd) begin
                a_rdy = 0; a_ovr = 0; a_nse = 0; a_frm = 0; a_idl = 0;
            end
            fire = 0;
            if (!line_lvl) begin
                m_armed = 1; m_cnt = 0;
            end else if (m_armed && bit_tick) begin
                m_cnt++;
                if (m_cnt == 10) begin fire = 1; m_armed = 0; m_cnt = 0; end
            end
            take = char_done && (!m_rdy || c_rdy);
            if (c_rdy) m_rdy = 0;
            if (c_ovr) m_ovr = 0;
            if (c_nse) m_nse = 0;
            if (c_frm) m_frm = 0;
            if (c_idl) m_idl = 0;
            if (take) begin
                m_rdy = 1; m_data = int'(char_data); m_nse = char_noise; m_frm = char_frame;
            end else if (char_done) begin
                m_ovr = 1;
            end
            if (fire) m_idl = 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit m_irq;
        m_irq = (ie_rx && (m_rdy || m_ovr)) || (ie_idle && m_idl);
        chk("R1 data", int'(rx_data), m_data);
        chk("R1 ready", int'(flg_ready), int'(m_rdy));
        chk("R2 overrun", int'(flg_overrun), int'(m_ovr));
        chk("R3 noise", int'(flg_noise), int'(m_nse));
        chk("R3 frame", int'(flg_frame), int'(m_frm));
        chk("R4 idle", int'(flg_idle), int'(m_idl));
        chk("R7 irq", int'(irq), int'(m_irq));
    endtask

    // compare at the falling edge, then apply inputs for the next edge
    task automatic cyc(input bit dn, input logic [7:0] d, input bit ns, input bit fr,
                       input bit tk, input bit ln, input bit sr, input bit dr);
        @(negedge clk);
        compare_all();
        char_done = dn; char_data = d; char_noise = ns; char_frame = fr;
        bit_tick = tk; line_lvl = ln; stat_rd = sr; data_rd = dr;
    endtask

    task automatic idle_c(); cyc(0, 8'h00, 0, 0, 0, 1, 0, 0); endtask
    task automatic tick_c(); cyc(0, 8'h00, 0, 0, 1, 1, 0, 0); endtask
    task automatic clear_seq();
        cyc(0, 8'h00, 0, 0, 0, 1, 1, 0);
        cyc(0, 8'h00, 0, 0, 0, 1, 0, 1);
        idle_c();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 reset flags", int'({flg_ready, flg_overrun, flg_noise, flg_frame, flg_idle}), 0);
        chk("R10 reset data", int'(rx_data), 0);
        chk("R10 reset irq", int'(irq), 0);
        rst_n = 1;
        ie_rx = 1;
        idle_c();
        // R1, R3 first character
        cyc(1, 8'hA5, 1, 0, 0, 1, 0, 0);
        idle_c();
        chk("R1 stored", int'(rx_data), 'hA5);
        chk("R3 noise loaded", int'(flg_noise), 1);
        chk("R7 irq on ready", int'(irq), 1);
        // R2 overrun keeps stored character
        cyc(1, 8'h3C, 0, 1, 0, 1, 0, 0);
        idle_c();
        chk("R2 kept data", int'(rx_data), 'hA5);
        chk("R2 overrun set", int'(flg_overrun), 1);
        chk("R2 frame kept", int'(flg_frame), 0);
        // R8 data read alone clears nothing
        cyc(0, 8'h00, 0, 0, 0, 1, 0, 1);
        idle_c();
        chk("R8 ready kept", int'(flg_ready), 1);
        clear_seq();
        chk("R8 ready cleared", int'(flg_ready), 0);
        chk("R8 overrun cleared", int'(flg_overrun), 0);
        // R9 character coinciding with the clearing data read
        cyc(1, 8'h11, 0, 0, 0, 1, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 1, 1, 0);
        cyc(1, 8'h22, 0, 1, 0, 1, 0, 1);
        idle_c();
        chk("R9 accepted data", int'(rx_data), 'h22);
        chk("R9 no overrun", int'(flg_overrun), 0);
        chk("R9 ready set wins", int'(flg_ready), 1);
        clear_seq();
        // R5 no idle without prior activity
        ie_idle = 1;
        for (int i = 0; i < 12; i++) tick_c();
        idle_c();
        chk("R5 disarmed after reset", int'(flg_idle), 0);
        // R4 idle after ten high ticks
        cyc(0, 8'h00, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 9; i++) tick_c();
        idle_c();
        chk("R4 not yet idle", int'(flg_idle), 0);
        tick_c();
        idle_c();
        chk("R4 idle set", int'(flg_idle), 1);
        chk("R7 idle irq", int'(irq), 1);
        clear_seq();
        for (int i = 0; i < 20; i++) tick_c();
        idle_c();
        chk("R5 no second idle", int'(flg_idle), 0);
        // R6 restart on a low line
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) tick_c();
        cyc(0, 8'h00, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 9; i++) tick_c();
        idle_c();
        chk("R6 count restarted", int'(flg_idle), 0);
        tick_c();
        idle_c();
        chk("R6 idle after restart", int'(flg_idle), 1);
        // random phase, compared every clock against the model
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin ie_rx = $urandom_range(0, 1); ie_idle = $urandom_range(0, 1); end
            cyc(($urandom_range(0, 15) == 0), 8'($urandom), $urandom_range(0, 1),
                $urandom_range(0, 1), ($urandom_range(0, 1) == 0),
                ($urandom_range(0, 40) != 0), ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 7) == 0));
        end
        idle_c();
        idle_c();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule